// File: doc/BRIEF.md
# Double-Edge Link Word Deserializer

This block sits at the receiving end of a two-wire serial video link made of a link clock and a link data line. The analog receivers are outside the block: it sees the two lines as digital levels, plus a separate "link active" level that is high once the line has left its start-up pattern. A free-running system clock oversamples all three signals. The block detects every rising and falling transition of the link clock and takes one data bit at each transition. From these bits it rebuilds words of eight pixel data bits followed by a vertical-sync bit and a horizontal-sync bit.

No framing code is sent. The first bit of a word is the first rising link-clock transition that arrives while the link is active. Each later group of ten transitions forms the next word. The block presents each complete word on a parallel bus, together with a regenerated pixel clock at one fifth of the link-clock rate and a flag that marks the first word after the link comes up. A low on the power enable forces every parallel output low and drops any word in progress.

Top module: `ddr_link_deser`

## Requirements
- R1: After a synchronous reset, pixel data, both sync outputs, the pixel clock and the first-word flag are all low.
- R2: A data bit is taken at every rising and every falling transition of the link clock. A word therefore spans ten transitions, which is five link-clock cycles.
- R3: Bit order within a word: the first bit received goes to pix_data_o[0], and each following bit goes to the next higher data bit up to pix_data_o[7]. The ninth bit goes to pix_vs_o and the tenth to pix_hs_o.
- R4: The first bit of a word is the first rising link-clock transition seen while the link is active. Transitions seen while the link is inactive are ignored, as is a falling transition that comes before that first rising one.
- R5: pix_clk_o goes high when a new word is presented. It goes low at the fifth transition of the word that follows, so it is high for five transitions and low for five.
- R6: The parallel outputs change only when all ten bits of a word have arrived. At every other time they keep their value.
- R7: When link-active drops, any partly received word is discarded. While the link is inactive the last complete word is held and pix_clk_o and first_word_o are low.
- R8: first_word_o is high while the first complete word after reset, power-up or link activation is presented, and low from the next word on.
- R9: While pwr_en_i is low, every parallel output and first_word_o are low and any word in progress is discarded.
- R10: Each input passes two synchronizer stages and one output register. A transition present on the inputs at system clock edge k shows at the outputs just after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System oversampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pwr_en_i | input | 1 | Power enable, low means power down |
| link_act_i | input | 1 | High while the link is in active transfer |
| link_clk_i | input | 1 | Received link clock level |
| link_dat_i | input | 1 | Received link data level |
| pix_data_o | output | DATA_W | Recovered pixel data byte |
| pix_vs_o | output | 1 | Recovered vertical sync |
| pix_hs_o | output | 1 | Recovered horizontal sync |
| pix_clk_o | output | 1 | Regenerated pixel clock |
| first_word_o | output | 1 | Marks the first word after activation |

## Verification
The checks assume that link-clock transitions alternate cleanly and that each link-clock level lasts for at least two system clocks. They also assume that the data level never changes in the same system cycle as a clock transition, so the synchronized data is already settled when the edge is detected. The stimulus sets the data one system cycle before each clock toggle and then holds both lines for two more cycles. It holds link-active and power enable steady across whole stretches of link activity, and changes them only between transitions.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;

    localparam int PIX_W_DEF  = 8;
    localparam int SYNC_DEF   = 2;
    localparam int SIDE_BITS  = 2;

    // Raw and synchronized view of the link-side inputs
    typedef struct packed {
        logic en;
        logic act;
        logic lclk;
        logic dat;
    } link_t;

    typedef enum logic {
        ASM_WAIT = 1'b0,
        ASM_RUN  = 1'b1
    } asm_state_t;

    function automatic int word_bits(input int data_w);
        return data_w + SIDE_BITS;
    endfunction

endpackage

// File: rtl/ddr_link_sync.sv
module ddr_link_sync
    import ddr_deser_pkg::*;
#(
    parameter int STAGES = SYNC_DEF
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  link_t raw_i,
    output link_t cur_o,
    output logic  rise_o,
    output logic  fall_o
);

    link_t chain_q [STAGES];
    logic  prev_clk_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
            prev_clk_q <= 1'b0;
        end else begin
            chain_q[0] <= raw_i;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            prev_clk_q <= chain_q[STAGES-1].lclk;
        end
    end

    assign cur_o  = chain_q[STAGES-1];
    assign rise_o = cur_o.lclk & ~prev_clk_q;
    assign fall_o = ~cur_o.lclk & prev_clk_q;

endmodule

// File: rtl/ddr_bit_assembler.sv
module ddr_bit_assembler
    import ddr_deser_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic              act_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              dat_i,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic              mid_o
);

    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] MID_IDX  = IDX_W'(WORD_W / 2 - 1);

    asm_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-2:0] shreg_q;
    logic              any_edge;
    logic              live;

    assign any_edge     = rise_i | fall_i;
    assign live         = en_i & act_i & (state_q == ASM_RUN) & any_edge;
    assign word_valid_o = live & (idx_q == LAST_IDX);
    assign mid_o        = live & (idx_q == MID_IDX);
    assign word_o       = {dat_i, shreg_q};

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i || !act_i) begin
            state_q <= ASM_WAIT;
            idx_q   <= '0;
            shreg_q <= '0;
        end else begin
            case (state_q)
                ASM_WAIT: begin
                    if (rise_i) begin
                        shreg_q[0] <= dat_i;
                        idx_q      <= IDX_W'(1);
                        state_q    <= ASM_RUN;
                    end
                end
                ASM_RUN: begin
                    if (any_edge) begin
                        if (idx_q == LAST_IDX) begin
                            idx_q <= '0;
                        end else begin
                            shreg_q[idx_q] <= dat_i;
                            idx_q          <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= ASM_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/ddr_word_out.sv
module ddr_word_out
    import ddr_deser_pkg::*;
#(
    parameter int DATA_W = PIX_W_DEF
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        en_i,
    input  logic                        act_i,
    input  logic                        valid_i,
    input  logic [word_bits(DATA_W)-1:0] word_i,
    input  logic                        mid_i,
    output logic [DATA_W-1:0]           data_o,
    output logic                        vs_o,
    output logic                        hs_o,
    output logic                        pclk_o,
    output logic                        first_o
);

    logic armed_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            data_o  <= '0;
            vs_o    <= 1'b0;
            hs_o    <= 1'b0;
            pclk_o  <= 1'b0;
            first_o <= 1'b0;
            armed_q <= 1'b1;
        end else if (!act_i) begin
            pclk_o  <= 1'b0;
            first_o <= 1'b0;
            armed_q <= 1'b1;
        end else if (valid_i) begin
            data_o  <= word_i[DATA_W-1:0];
            vs_o    <= word_i[DATA_W];
            hs_o    <= word_i[DATA_W+1];
            pclk_o  <= 1'b1;
            first_o <= armed_q;
            armed_q <= 1'b0;
        end else if (mid_i) begin
            pclk_o  <= 1'b0;
        end
    end

endmodule

// File: rtl/ddr_link_deser.sv
module ddr_link_deser
    import ddr_deser_pkg::*;
#(
    parameter int DATA_W      = PIX_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              pwr_en_i,
    input  logic              link_act_i,
    input  logic              link_clk_i,
    input  logic              link_dat_i,
    output logic [DATA_W-1:0] pix_data_o,
    output logic              pix_vs_o,
    output logic              pix_hs_o,
    output logic              pix_clk_o,
    output logic              first_word_o
);

    localparam int WORD_W = word_bits(DATA_W);

    link_t             raw;
    link_t             cur;
    logic              rise, fall;
    logic              en_s, act_s;
    logic              word_valid;
    logic              mid;
    logic [WORD_W-1:0] word;

    assign raw = '{en: pwr_en_i, act: link_act_i, lclk: link_clk_i, dat: link_dat_i};
    assign en_s  = cur.en;
    assign act_s = cur.act;

    ddr_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .raw_i  (raw),
        .cur_o  (cur),
        .rise_o (rise),
        .fall_o (fall)
    );

    ddr_bit_assembler #(.WORD_W(WORD_W)) u_asm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .en_i         (en_s),
        .act_i        (act_s),
        .rise_i       (rise),
        .fall_i       (fall),
        .dat_i        (cur.dat),
        .word_valid_o (word_valid),
        .word_o       (word),
        .mid_o        (mid)
    );

    ddr_word_out #(.DATA_W(DATA_W)) u_out (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_s),
        .act_i   (act_s),
        .valid_i (word_valid),
        .word_i  (word),
        .mid_i   (mid),
        .data_o  (pix_data_o),
        .vs_o    (pix_vs_o),
        .hs_o    (pix_hs_o),
        .pclk_o  (pix_clk_o),
        .first_o (first_word_o)
    );

endmodule

// File: rtl/ddr_link_deser_chk.sv
module ddr_link_deser_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en_s,
    input logic              act_s,
    input logic              word_valid,
    input logic [DATA_W-1:0] data,
    input logic              vs,
    input logic              hs,
    input logic              pclk,
    input logic              first
);

    // R9: power down drives every parallel output low
    a_r9_pd_outputs_low: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> (data == '0 && !vs && !hs && !pclk && !first));

    // R6: word outputs hold unless a complete word was assembled
    a_r6_hold_between_words: assert property (@(posedge clk) disable iff (rst)
        (en_s && !word_valid) |=> $stable({data, vs, hs}));

    // R5: pixel clock rises only with a freshly completed word
    a_r5_pclk_rises_with_word: assert property (@(posedge clk) disable iff (rst)
        $rose(pclk) |-> $past(word_valid));

    // R8: the first-word flag only comes up together with a new pixel clock pulse
    a_r8_first_with_pclk: assert property (@(posedge clk) disable iff (rst)
        $rose(first) |-> $rose(pclk));

    // R7: inactive link keeps pixel clock and flag low
    a_r7_inactive_quiet: assert property (@(posedge clk) disable iff (rst)
        (en_s && !act_s) |=> (!pclk && !first));

endmodule

bind ddr_link_deser ddr_link_deser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk_i),
    .rst        (rst_i),
    .en_s       (en_s),
    .act_s      (act_s),
    .word_valid (word_valid),
    .data       (pix_data_o),
    .vs         (pix_vs_o),
    .hs         (pix_hs_o),
    .pclk       (pix_clk_o),
    .first      (first_word_o)
);

// File: tb/tb_ddr_link_deser.sv
`timescale 1ns/1ps
module tb_ddr_link_deser;

    logic       clk = 1'b0;
    logic       rst;
    logic       pwr_en, link_act, link_clk, link_dat;
    logic [7:0] pix_data;
    logic       pix_vs, pix_hs, pix_clk, first_word;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;
    bit mon_on   = 0;

    always #4 clk = ~clk;

    ddr_link_deser dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .pwr_en_i     (pwr_en),
        .link_act_i   (link_act),
        .link_clk_i   (link_clk),
        .link_dat_i   (link_dat),
        .pix_data_o   (pix_data),
        .pix_vs_o     (pix_vs),
        .pix_hs_o     (pix_hs),
        .pix_clk_o    (pix_clk),
        .first_word_o (first_word)
    );

    // ---------------- behavioural reference model ----------------
    bit [11:0] pipe [$];
    bit [11:0] cur_exp;
    bit        m_run, m_pclk, m_first, m_armed, p_clk;
    int        m_idx;
    bit [9:0]  m_bits;
    bit [9:0]  m_word;

    always @(posedge clk) begin
        if (rst) begin
            pipe = {12'h0, 12'h0};
            cur_exp = '0;
            m_run = 0; m_idx = 0; m_bits = '0; m_word = '0;
            m_pclk = 0; m_first = 0; m_armed = 1; p_clk = 0;
        end else begin
            bit rise_e, fall_e;
            rise_e = link_clk && !p_clk;
            fall_e = !link_clk && p_clk;
            p_clk  = link_clk;
            if (!pwr_en) begin
                m_run = 0; m_idx = 0; m_word = '0;
                m_pclk = 0; m_first = 0; m_armed = 1;
            end else if (!link_act) begin
                m_run = 0; m_idx = 0; m_pclk = 0; m_first = 0; m_armed = 1;
            end else if (!m_run) begin
                if (rise_e) begin
                    m_bits[0] = link_dat; m_idx = 1; m_run = 1;
                end
            end else if (rise_e || fall_e) begin
                m_bits[m_idx] = link_dat;
                if (m_idx == 9) begin
                    m_word = m_bits; m_pclk = 1; m_first = m_armed; m_armed = 0; m_idx = 0;
                end else begin
                    if (m_idx == 4) m_pclk = 0;
                    m_idx++;
                end
            end
            pipe.push_back({m_first, m_pclk, m_word});
            cur_exp = pipe.pop_front();
        end
    end

    // every-cycle comparison, away from the active edge (R10 latency built into the model)
    always @(negedge clk) begin
        if (mon_on && !done) begin
            checks++;
            if (pix_data !== cur_exp[7:0]) begin
                failures++;
                $display("FAIL R3 model data act=%h exp=%h t=%0t", pix_data, cur_exp[7:0], $time);
            end else if ({pix_hs, pix_vs} !== cur_exp[9:8]) begin
                failures++;
                $display("FAIL R3 model sync act=%b exp=%b t=%0t", {pix_hs, pix_vs}, cur_exp[9:8], $time);
            end else if (pix_clk !== cur_exp[10]) begin
                failures++;
                $display("FAIL R5 model pclk act=%b exp=%b t=%0t", pix_clk, cur_exp[10], $time);
            end else if (first_word !== cur_exp[11]) begin
                failures++;
                $display("FAIL R8 model first act=%b exp=%b t=%0t", first_word, cur_exp[11], $time);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic link_bit(input logic b);
        @(negedge clk) link_dat = b;
        @(negedge clk) link_clk = ~link_clk;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_range(input logic [9:0] w, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) link_bit(w[i]);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst = 1; pwr_en = 0; link_act = 0; link_clk = 0; link_dat = 0;
        wait_n(4);
        mon_on = 1;
        chk("R1 reset outputs", {21'h0, first_word, pix_clk, pix_hs, pix_vs, pix_data}, 32'h0);
        rst = 0;

        // R4: transitions while inactive are ignored
        pwr_en = 1;
        wait_n(3);
        send_range(10'h3FF, 0, 3);
        wait_n(3);
        chk("R4 inactive ignored", {first_word, pix_clk, pix_data}, 32'h0);

        // R3/R8/R5/R10: first word
        link_act = 1;
        wait_n(3);
        send_range({1'b0, 1'b1, 8'hA5}, 0, 9);
        chk("R10 not yet updated", {24'h0, pix_data}, 32'h0);
        wait_n(1);
        chk("R3 data byte", {24'h0, pix_data}, 32'hA5);
        chk("R3 sync bits", {30'h0, pix_hs, pix_vs}, 32'h1);
        chk("R5 pclk high on word", {31'h0, pix_clk}, 32'h1);
        chk("R8 first flag set", {31'h0, first_word}, 32'h1);

        send_range({1'b1, 1'b0, 8'h3C}, 0, 9);
        wait_n(1);
        chk("R3 second word", {22'h0, pix_hs, pix_vs, pix_data}, {22'h0, 2'b10, 8'h3C});
        chk("R8 first flag cleared", {31'h0, first_word}, 32'h0);

        // R6/R5: partial word does not change outputs, pclk low after fifth edge
        send_range({2'b00, 8'hFF}, 0, 5);
        wait_n(3);
        chk("R6 hold mid-word", {24'h0, pix_data}, 32'h3C);
        chk("R5 pclk low after fifth edge", {31'h0, pix_clk}, 32'h0);
        send_range({2'b00, 8'hFF}, 6, 9);
        wait_n(1);
        chk("R2 both-edge word", {22'h0, pix_hs, pix_vs, pix_data}, {22'h0, 2'b00, 8'hFF});

        // R7: partial word discarded on link drop
        send_range({2'b11, 8'h81}, 0, 5);
        link_act = 0;
        wait_n(4);
        chk("R7 held word", {24'h0, pix_data}, 32'hFF);
        chk("R7 pclk and flag low", {30'h0, pix_clk, first_word}, 32'h0);
        link_act = 1;
        wait_n(3);
        send_range({2'b10, 8'h42}, 0, 9);
        wait_n(1);
        chk("R7 fresh alignment", {22'h0, pix_hs, pix_vs, pix_data}, {22'h0, 2'b10, 8'h42});
        chk("R8 first after reactivation", {31'h0, first_word}, 32'h1);

        // R4: clock high at activation, leading falling edge ignored
        link_act = 0;
        @(negedge clk) link_clk = 1;
        wait_n(3);
        link_act = 1;
        wait_n(3);
        link_bit(1'b1);
        send_range({2'b11, 8'h96}, 0, 9);
        wait_n(1);
        chk("R4 align to first rise", {22'h0, pix_hs, pix_vs, pix_data}, {22'h0, 2'b11, 8'h96});

        // R9: power down mid-word
        send_range({2'b00, 8'h55}, 0, 3);
        pwr_en = 0;
        wait_n(4);
        chk("R9 power down outputs", {21'h0, first_word, pix_clk, pix_hs, pix_vs, pix_data}, 32'h0);
        pwr_en = 1;
        wait_n(3);
        send_range({2'b01, 8'h0F}, 0, 9);
        wait_n(1);
        chk("R9 recovery word", {22'h0, pix_hs, pix_vs, pix_data}, {22'h0, 2'b01, 8'h0F});
        chk("R8 first after power up", {31'h0, first_word}, 32'h1);

        wait_n(5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule